// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Wake-Up Detector

This block sits on the slave side of an open-drain two-wire bus. It brings the clock line and the data line into the system clock domain and finds start and stop conditions. It then shifts the first byte after each start, most significant bit first, and compares that byte with a programmable slave address. A wake-up enable lets the block stay quiet through traffic meant for other devices. With the enable set, one interrupt pulse comes out when the address byte matches, and another when a stop condition ends the transfer. While the enable is set, the data line driver is always released.

The same shift register serves normal reception. Software loads it through a load port, and received bits then shift into it. The open-drain data driver pulls the line low whenever the register's most significant bit is 0. For this reason the register must hold all ones before a normal reception, so that the line is left free.

Top module: `i2cw_wake_det`

## Requirements
- R1: After reset `irq` is 0, `sda_oe` is 0 and `shift_q` holds all ones.
- R2: With `wake_en` set at the start condition, an address byte equal to `slave_addr` gives exactly one `irq` pulse, one clock wide, after the eighth SCL rising edge.
- R3: An address byte that differs from `slave_addr` in any bit gives no address interrupt.
- R4: With `wake_en` clear at the start condition, a matching address byte gives no interrupt.
- R5: A stop condition (SDA rising while SCL is high) pulses `irq` when `wake_en` is 1 and does nothing when `wake_en` is 0.
- R6: While `wake_en` is 1, `sda_oe` is 0 whatever `shift_q` holds.
- R7: While `wake_en` is 0, `sda_oe` is 1 exactly when bit 7 (the MSB) of `shift_q` is 0.
- R8: The value of `wake_en` at the start condition governs that address byte. Setting it after the start does not enable the address interrupt for that byte.
- R9: After a match, later bytes of the same transfer give no address interrupt, even when they equal `slave_addr`, until the next start.
- R10: A repeated start (a start with no stop before it) resets the bit count, so the next eight bits form a fresh address byte.
- R11: A pulse on `shift_load` copies `shift_din` into `shift_q` one clock later. If the load lands in the same cycle as a received bit, the load wins.
- R12: Bits shift into `shift_q` MSB first on SCL rising edges, eight per byte. The ninth (acknowledge) clock does not shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, sampled as a plain input |
| sda_i | input | 1 | Bus data line as read from the pad |
| wake_en | input | 1 | Wake-up mode enable |
| slave_addr | input | 8 | Programmed slave address byte |
| shift_load | input | 1 | Load strobe for the shift register |
| shift_din | input | 8 | Value to load into the shift register |
| shift_q | output | 8 | Shift register contents |
| sda_oe | output | 1 | Open-drain enable, 1 pulls the data line low |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
A software load of the shift register and a received bit can land on the same system clock edge. Only the load may survive. The bench provokes this inside a normal-mode transfer. It raises SCL and then pulses `shift_load` with all zeros, timed to the edge at which the synchronized rising edge is acted on. It then checks that `shift_q` reads all zeros, and not the old ones shifted left with the received 1. `sda_oe` is also checked, because it follows the surviving MSB.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
   } bus_evt_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("i2cw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= RST_VAL;
         else if (i == 0) chain[i] <= d;
         else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events
   import i2cw_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   always_comb begin
      evt.start = scl_s & scl_p & sda_p & ~sda_s;
      evt.stop  = scl_s & scl_p & ~sda_p & sda_s;
      evt.rise  = scl_s & ~scl_p;
   end

   // R12
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.rise |=> !evt.rise);

   // R5
   cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.start |=> !evt.stop);
endmodule

// File: rtl/i2cw_addr_unit.sv
module i2cw_addr_unit
   import i2cw_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit IGNORE_LSB = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_evt_t          evt,
   input  logic              sda_s,
   input  logic              wake_en,
   input  logic [DATA_W-1:0] slave_addr,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic [DATA_W-1:0] shift_q,
   output logic              irq
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W);

   if (DATA_W < 2) begin : g_bad_width
      $error("i2cw_addr_unit: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] cmp_mask;
   if (IGNORE_LSB) begin : g_mask_rw
      assign cmp_mask = {{(DATA_W-1){1'b1}}, 1'b0};
   end else begin : g_mask_full
      assign cmp_mask = {DATA_W{1'b1}};
   end

   logic [DATA_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic              in_xfer, addr_ph, armed, irq_q;
   logic [DATA_W-1:0] cand;
   logic              last_bit, match, fire, do_shift;

   assign cand     = {shreg[DATA_W-2:0], sda_s};
   assign match    = ((cand ^ slave_addr) & cmp_mask) == '0;
   assign last_bit = evt.rise & in_xfer & addr_ph & (cnt == LAST_BIT);
   assign fire     = last_bit & armed & match;
   assign do_shift = evt.rise & in_xfer & (cnt != ACK_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '1;
      end else if (load) begin
         shreg <= load_data;
      end else if (do_shift) begin
         shreg <= cand;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         in_xfer <= 1'b0;
         addr_ph <= 1'b0;
         armed   <= 1'b0;
      end else if (evt.start) begin
         cnt     <= '0;
         in_xfer <= 1'b1;
         addr_ph <= 1'b1;
         armed   <= wake_en;
      end else if (evt.stop) begin
         cnt     <= '0;
         in_xfer <= 1'b0;
         addr_ph <= 1'b0;
         armed   <= 1'b0;
      end else if (evt.rise && in_xfer) begin
         if (cnt == ACK_BIT) begin
            cnt     <= '0;
            addr_ph <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
         if (fire) armed <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= fire | (evt.stop & wake_en);
   end

   assign shift_q = shreg;
   assign irq     = irq_q;

   // R10
   start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.start |=> (cnt == '0));

   // R11
   load_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (shreg == $past(load_data)));

   // R9
   disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !armed);

   // R2
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);

   // R3
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(fire || (evt.stop && wake_en)));

   // R12
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= ACK_BIT);
endmodule

// File: rtl/i2cw_wake_det.sv
module i2cw_wake_det
   import i2cw_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit IGNORE_LSB  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              wake_en,
   input  logic [DATA_W-1:0] slave_addr,
   input  logic              shift_load,
   input  logic [DATA_W-1:0] shift_din,
   output logic [DATA_W-1:0] shift_q,
   output logic              sda_oe,
   output logic              irq
);
   localparam int MSB = DATA_W - 1;

   logic     scl_s, sda_s;
   bus_evt_t evt;

   i2cw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));

   i2cw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   i2cw_bus_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .evt(evt));

   i2cw_addr_unit #(.DATA_W(DATA_W), .IGNORE_LSB(IGNORE_LSB)) u_addr (
      .clk(clk), .rst_n(rst_n), .evt(evt), .sda_s(sda_s),
      .wake_en(wake_en), .slave_addr(slave_addr),
      .load(shift_load), .load_data(shift_din),
      .shift_q(shift_q), .irq(irq));

   assign sda_oe = ~wake_en & ~shift_q[MSB];

   // R6
   wake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_en && $stable(wake_en)) |-> !sda_oe);

   // R7
   oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wake_en && $past(shift_load) && !$past(wake_en))
         |-> (sda_oe == !$past(shift_din[MSB])));
endmodule

// File: tb/i2cw_wake_det_bench.sv
module i2cw_wake_det_bench;
   localparam int HALF = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_i = 1'b1, sda_i = 1'b1;
   logic       wake_en = 1'b0;
   logic [7:0] slave_addr = 8'h00;
   logic       shift_load = 1'b0;
   logic [7:0] shift_din = 8'h00;
   logic [7:0] shift_q;
   logic       sda_oe, irq;

   int tests = 0, fails = 0, irq_cnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   i2cw_wake_det u_i2cw_wake_det (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .wake_en(wake_en), .slave_addr(slave_addr),
      .shift_load(shift_load), .shift_din(shift_din),
      .shift_q(shift_q), .sda_oe(sda_oe), .irq(irq));

   always @(negedge clk) if (irq) irq_cnt++;

   // wake, slave address, sent byte, expected address irqs, expected stop irqs
   localparam logic [24:0] VEC [0:5] = '{
      {1'b1, 8'h5A, 8'h5A, 4'd1, 4'd1},
      {1'b1, 8'h5A, 8'h5B, 4'd0, 4'd1},
      {1'b0, 8'h5A, 8'h5A, 4'd0, 4'd0},
      {1'b1, 8'h80, 8'h80, 4'd1, 4'd1},
      {1'b1, 8'h80, 8'h01, 4'd0, 4'd1},
      {1'b0, 8'h3C, 8'hC3, 4'd0, 4'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      sda_i = 1'b0; wt(HALF);
      scl_i = 1'b0; wt(HALF);
   endtask

   task automatic do_rstart();
      sda_i = 1'b1; wt(HALF);
      scl_i = 1'b1; wt(HALF);
      sda_i = 1'b0; wt(HALF);
      scl_i = 1'b0; wt(HALF);
   endtask

   task automatic do_stop();
      sda_i = 1'b0; wt(HALF);
      scl_i = 1'b1; wt(HALF);
      sda_i = 1'b1; wt(HALF);
   endtask

   task automatic send_bit(input logic b);
      sda_i = b;    wt(HALF);
      scl_i = 1'b1; wt(HALF);
      scl_i = 1'b0; wt(HALF);
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      send_bit(1'b1);
   endtask

   task automatic do_load(input logic [7:0] v);
      shift_din = v; shift_load = 1'b1; wt(1);
      shift_load = 1'b0; wt(1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int base;
      wt(3);
      // R1 reset state
      chk("R1 irq", irq, 0);
      chk("R1 sda_oe", sda_oe, 0);
      chk("R1 shift_q", shift_q, 8'hFF);
      rst_n = 1'b1;
      wt(4);

      // table walk: R2 R3 R4 R5 R12
      foreach (VEC[k]) begin
         wake_en = VEC[k][24];
         slave_addr = VEC[k][23:16];
         do_load(8'hFF);
         base = irq_cnt;
         do_start();
         send_byte(VEC[k][15:8]);
         wt(4);
         chk("R2/R3/R4 address irq", irq_cnt - base, VEC[k][7:4]);
         chk("R12 shifted byte", shift_q, VEC[k][15:8]);
         base = irq_cnt;
         do_stop();
         wt(4);
         chk("R5 stop irq", irq_cnt - base, VEC[k][3:0]);
      end

      // R7 / R6 driver control
      wake_en = 1'b0;
      do_load(8'h00);
      chk("R7 oe on MSB 0", sda_oe, 1);
      do_load(8'h80);
      chk("R7 oe on MSB 1", sda_oe, 0);
      do_load(8'h00);
      wake_en = 1'b1; wt(1);
      chk("R6 wake releases", sda_oe, 0);

      // R8 enable raised after start
      wake_en = 1'b0; slave_addr = 8'h42;
      base = irq_cnt;
      do_start();
      wake_en = 1'b1;
      send_byte(8'h42);
      wt(4);
      chk("R8 late enable", irq_cnt - base, 0);
      do_stop(); wt(4);
      chk("R5 stop with wake", irq_cnt - base, 1);

      // R9 second byte equal to address
      base = irq_cnt;
      do_start();
      send_byte(8'h42);
      send_byte(8'h42);
      wt(4);
      chk("R9 no second irq", irq_cnt - base, 1);
      do_stop(); wt(4);

      // R10 repeated start after a partial byte
      base = irq_cnt;
      do_start();
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      do_rstart();
      send_byte(8'h42);
      wt(4);
      chk("R10 repeated start match", irq_cnt - base, 1);
      do_stop(); wt(4);

      // R11 load and received bit on the same edge
      wake_en = 1'b0;
      do_load(8'hFF);
      base = irq_cnt;
      do_start();
      sda_i = 1'b1; wt(HALF);
      scl_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      shift_din = 8'h00; shift_load = 1'b1;
      @(negedge clk);
      shift_load = 1'b0;
      chk("R11 load wins", shift_q, 8'h00);
      chk("R11 oe follows load", sda_oe, 1);
      wt(HALF);
      scl_i = 1'b0; wt(HALF);
      send_bit(1'b1);
      chk("R12 shift after load", shift_q, 8'h01);
      for (int i = 0; i < 7; i++) send_bit(1'b0);
      do_stop(); wt(4);
      chk("R5 stop without wake", irq_cnt - base, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule